// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This controller sits between a processor and a DRAM array whose address pins carry the row and the column one after the other. The processor presents a full word address and a read/write flag in a single valid/ready request. The controller sends the row bits with the row strobe raised, then the column bits with the column strobe, and drives chip select and the memory-side read/write flag. The data lines connect the processor straight to the memory and do not pass through this block.

After an access the row stays open. A later request to the same row goes straight to a column strobe, with no new row phase (page mode). A request to another row closes the page for one cycle and then opens the new row. A refresh interval timer raises a pending flag every `REFI` clocks. The pending refresh is serviced only between transactions: any open page is closed first, then the next row in ascending order is strobed for four clocks. The row counter wraps after the last row.

The request channel follows the usual valid/ready rules. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. The processor must hold the address and the flag steady while `req_ready` is low. `req_ready` is never high while a refresh is pending or while a transaction is in progress. With a page open, `req_ready` is high only for an address whose row matches the open row.

Top module: `dram_mux_ctl`

## Requirements
- R1: While reset is held, `mem_ras`, `mem_cas`, `mem_cs` and `xfer_done` are 0, `mem_rd` is 1 and `req_ready` is 1.
- R2: The cycle after a request is accepted with no page open, `mem_addr` carries the row, which is `req_addr[ADDR_W-1:COL_W]`, with `mem_ras`=1 and `mem_cas`=0. The next cycle carries the column, which is `req_addr[COL_W-1:0]` zero-extended, with `mem_ras`=1 and `mem_cas`=1.
- R3: In the column-strobe cycle, `mem_cs`=1 and `mem_rd` equals the accepted `req_rd`, where 1 means read and 0 means write. Outside that cycle `mem_rd` is 1.
- R4: `xfer_done` is high for exactly one cycle per transaction, in its column-strobe cycle.
- R5: With a page open, a request whose row matches is accepted, and its column strobe follows in the next cycle while `mem_ras` stays high.
- R6: With a page open, a request to another row sees `req_ready`=0. The next cycle has `mem_ras`, `mem_cs` and `mem_cas` all at 0, and the following cycle is idle and able to accept the request.
- R7: A refresh becomes pending every `REFI` clocks counted from reset. While it is pending, `req_ready` is 0.
- R8: A refresh holds `mem_ras`=1, `mem_cs`=1 and `mem_cas`=0 for 4 cycles, with `mem_addr` equal to the refresh row. The refresh row starts at 0, rises by one for each refresh and wraps to 0 after 2^ROW_W−1.
- R9: A pending refresh never interrupts an access that has started. If a page is open, one cycle with `mem_ras`=0 comes first, then the refresh begins.
- R10: A request held while `req_ready`=0 has no effect on the memory pins. With no request, an open page stays open with `mem_ras`=1 and `mem_cas`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Full word address (row bits high, column bits low) |
| req_rd | input | 1 | 1 = read, 0 = write |
| xfer_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | MA_W | Multiplexed row/column/refresh address |
| mem_ras | output | 1 | Row strobe, active high |
| mem_cas | output | 1 | Column strobe, active high |
| mem_cs | output | 1 | Chip select, active high |
| mem_rd | output | 1 | Memory read/write flag, 1 = read |

## Verification
Two things can fall in the same clock: the refresh timer can expire in the cycle a page-mode hit is accepted. The bench provokes this by streaming same-row requests with a short refresh interval, and it counts the cycles in which both events occur. The expected result is that the hit still completes its column strobe and completion pulse. Only after that does the page close for one cycle and the 4-cycle refresh of the next row start. A cycle-by-cycle reference model checks this together with every other pin in every clock.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ROW   = 3'd1,
    ST_COL   = 3'd2,
    ST_OPEN  = 3'd3,
    ST_CLOSE = 3'd4,
    ST_REF   = 3'd5
  } ctl_state_t;
endpackage

// File: rtl/dramc_refresh.sv
module dramc_refresh #(
  parameter int ROW_W   = 12,
  parameter int REFI    = 1039,
  parameter int REF_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_ref,
  output logic             pend,
  output logic [ROW_W-1:0] ref_row,
  output logic             ref_last
);
  localparam int TW = (REFI > 1) ? $clog2(REFI) : 1;
  localparam int CW = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;

  logic [TW-1:0] tmr;
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = (tmr == TW'(REFI - 1));
  assign ref_last = in_ref && (cnt == CW'(REF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr     <= '0;
      cnt     <= '0;
      pend    <= 1'b0;
      ref_row <= '0;
    end else begin
      tmr  <= tick ? '0 : tmr + 1'b1;
      cnt  <= (in_ref && !ref_last) ? cnt + 1'b1 : '0;
      pend <= (pend && !ref_last) || tick;
      if (ref_last) ref_row <= ref_row + 1'b1;
    end
  end

  // R8
  ref_row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ref_last) |-> (ref_row == $past(ref_row) + 1'b1));

  // R7
  ref_pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ref_last) |=> pend);

  // R8
  ref_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ref) |-> ($past(cnt) == CW'(REF_CYC - 1)));
endmodule

// File: rtl/dramc_page.sv
module dramc_page #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             drop,
  input  logic [ROW_W-1:0] row_in,
  input  logic [ROW_W-1:0] req_row,
  output logic             hit
);
  logic [ROW_W-1:0] open_row;
  logic             open_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_row <= '0;
      open_vld <= 1'b0;
    end else begin
      if (load) begin
        open_row <= row_in;
        open_vld <= 1'b1;
      end else if (drop) begin
        open_vld <= 1'b0;
      end
    end
  end

  assign hit = open_vld && (req_row == open_row);
endmodule

// File: rtl/dramc_strobe.sv
module dramc_strobe
  import dramc_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int MA_W  = 12
) (
  input  ctl_state_t       state,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] ref_row,
  input  logic             rd,
  output logic [MA_W-1:0]  mem_addr,
  output logic             mem_ras,
  output logic             mem_cas,
  output logic             mem_cs,
  output logic             mem_rd
);
  always_comb begin
    mem_addr = '0;
    mem_ras  = 1'b0;
    mem_cas  = 1'b0;
    mem_cs   = 1'b0;
    mem_rd   = 1'b1;
    unique case (state)
      ST_ROW: begin
        mem_addr[ROW_W-1:0] = row;
        mem_ras = 1'b1;
        mem_cs  = 1'b1;
      end
      ST_COL: begin
        mem_addr[COL_W-1:0] = col;
        mem_ras = 1'b1;
        mem_cas = 1'b1;
        mem_cs  = 1'b1;
        mem_rd  = rd;
      end
      ST_OPEN: begin
        mem_ras = 1'b1;
        mem_cs  = 1'b1;
      end
      ST_REF: begin
        mem_addr[ROW_W-1:0] = ref_row;
        mem_ras = 1'b1;
        mem_cs  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dram_mux_ctl.sv
module dram_mux_ctl
  import dramc_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int REFI    = 1039,
  parameter int REF_CYC = 4,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_rd,
  output logic              xfer_done,
  output logic [MA_W-1:0]   mem_addr,
  output logic              mem_ras,
  output logic              mem_cas,
  output logic              mem_cs,
  output logic              mem_rd
);
  ctl_state_t        state_q, state_d;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_rd;
  logic              pend, ref_last, hit, accept, drop;
  logic [ROW_W-1:0]  ref_row;

  dramc_refresh #(.ROW_W(ROW_W), .REFI(REFI), .REF_CYC(REF_CYC)) u_ref (
    .clk(clk), .rst_n(rst_n), .in_ref(state_q == ST_REF),
    .pend(pend), .ref_row(ref_row), .ref_last(ref_last)
  );

  dramc_page #(.ROW_W(ROW_W)) u_page (
    .clk(clk), .rst_n(rst_n),
    .load((state_q == ST_IDLE) && accept), .drop(drop),
    .row_in(req_addr[ADDR_W-1:COL_W]), .req_row(req_addr[ADDR_W-1:COL_W]),
    .hit(hit)
  );

  dramc_strobe #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_strobe (
    .state(state_q), .row(lat_addr[ADDR_W-1:COL_W]), .col(lat_addr[COL_W-1:0]),
    .ref_row(ref_row), .rd(lat_rd),
    .mem_addr(mem_addr), .mem_ras(mem_ras), .mem_cas(mem_cas),
    .mem_cs(mem_cs), .mem_rd(mem_rd)
  );

  always_comb begin
    unique case (state_q)
      ST_IDLE: req_ready = !pend;
      ST_OPEN: req_ready = !pend && hit;
      default: req_ready = 1'b0;
    endcase
  end

  assign accept    = req_valid && req_ready;
  assign drop      = (state_q == ST_OPEN) && (pend || (req_valid && !hit));
  assign xfer_done = (state_q == ST_COL);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (pend) state_d = ST_REF;
                else if (accept) state_d = ST_ROW;
      ST_ROW:   state_d = ST_COL;
      ST_COL:   state_d = ST_OPEN;
      ST_OPEN:  if (drop) state_d = ST_CLOSE;
                else if (accept) state_d = ST_COL;
      ST_CLOSE: state_d = pend ? ST_REF : ST_IDLE;
      ST_REF:   if (ref_last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      lat_addr <= '0;
      lat_rd   <= 1'b1;
    end else begin
      state_q <= state_d;
      if (accept) begin
        lat_addr <= req_addr;
        lat_rd   <= req_rd;
      end
    end
  end

  // R2
  cas_after_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cas |-> $past(mem_ras));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R5
  hit_no_reras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_OPEN) && accept) |=> (mem_cas && $past(mem_ras)));

  // R6
  miss_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_OPEN) && req_valid && !req_ready) |=> (!mem_ras && !mem_cs));
endmodule

// File: tb/dram_mux_ctl_test.sv
`timescale 1ns/1ps
module dram_mux_ctl_test;
  localparam int ROW_W = 5;
  localparam int COL_W = 4;
  localparam int REFI  = 30;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int ROWS = 1 << ROW_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_rd = 1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, xfer_done, mem_ras, mem_cas, mem_cs, mem_rd;
  logic [MA_W-1:0] mem_addr;

  dram_mux_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .REFI(REFI), .REF_CYC(4)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rd(req_rd), .xfer_done(xfer_done),
    .mem_addr(mem_addr), .mem_ras(mem_ras), .mem_cas(mem_cas),
    .mem_cs(mem_cs), .mem_rd(mem_rd)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit run = 0, fin = 0;

  // reference model: phase 0 closed, 1 row, 2 column, 3 page held, 4 closing, 5 refreshing
  int ph, pend, tmr, rleft, refrow, open_row, lrow, lcol, lrd;
  int n_hit, n_miss, n_refclose, n_wrap, n_held, n_rd, n_wr, n_coll, n_ref;

  function automatic int rq_row();
    return int'(req_addr) >> COL_W;
  endfunction

  function automatic int m_ready();
    if (ph == 0) return (pend == 0) ? 1 : 0;
    if (ph == 3) return (pend == 0 && rq_row() == open_row) ? 1 : 0;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; pend = 0; tmr = 0; rleft = 0; refrow = 0; open_row = 0;
      lrow = 0; lcol = 0; lrd = 1;
    end else begin
      int rdy, tick, rdone;
      rdy   = m_ready();
      tick  = (tmr == REFI - 1) ? 1 : 0;
      tmr   = (tick != 0) ? 0 : tmr + 1;
      rdone = (ph == 5 && rleft == 1) ? 1 : 0;
      if (req_valid && rdy == 0) n_held++;
      case (ph)
        0: if (pend != 0) begin ph = 5; rleft = 4; end
           else if (req_valid && rdy != 0) begin
             lrow = rq_row(); lcol = int'(req_addr) % (1 << COL_W); lrd = int'(req_rd);
             open_row = lrow; ph = 1;
           end
        1: ph = 2;
        2: begin if (lrd != 0) n_rd++; else n_wr++; ph = 3; end
        3: if (pend != 0) begin n_refclose++; ph = 4; end
           else if (req_valid && rdy != 0) begin
             n_hit++; if (tick != 0) n_coll++;
             lcol = int'(req_addr) % (1 << COL_W); lrd = int'(req_rd); ph = 2;
           end else if (req_valid) begin n_miss++; ph = 4; end
        4: if (pend != 0) begin ph = 5; rleft = 4; end else ph = 0;
        5: begin
             rleft--;
             if (rleft == 0) begin
               n_ref++;
               if (refrow == ROWS - 1) n_wrap++;
               refrow = (refrow + 1) % ROWS; ph = 0;
             end
           end
        default: ph = 0;
      endcase
      pend = ((pend != 0 && rdone == 0) || tick != 0) ? 1 : 0;
    end
  end

  // per-cycle comparison of every output pin against the model
  always @(negedge clk) begin
    if (run && rst_n) begin
      int e_ras, e_cas, e_cs, e_rd, e_addr, e_rdy, e_done;
      string tag;
      e_ras = 0; e_cas = 0; e_cs = 0; e_rd = 1; e_addr = 0; e_done = 0;
      e_rdy = m_ready();
      case (ph)
        0: tag = "R7 R10";
        1: begin e_ras = 1; e_cs = 1; e_addr = lrow; tag = "R2"; end
        2: begin e_ras = 1; e_cas = 1; e_cs = 1; e_addr = lcol; e_rd = lrd; e_done = 1; tag = "R3 R4"; end
        3: begin e_ras = 1; e_cs = 1; tag = "R5 R10"; end
        4: tag = "R6 R9";
        default: begin e_ras = 1; e_cs = 1; e_addr = refrow; tag = "R8"; end
      endcase
      checks++;
      if (int'(mem_ras) != e_ras || int'(mem_cas) != e_cas || int'(mem_cs) != e_cs ||
          int'(mem_rd) != e_rd || int'(mem_addr) != e_addr || int'(req_ready) != e_rdy ||
          int'(xfer_done) != e_done) begin
        fails++;
        $display("FAIL %s t=%0t act ras%b cas%b cs%b rd%b addr%0d rdy%b done%b exp ras%0d cas%0d cs%0d rd%0d addr%0d rdy%0d done%0d",
                 tag, $time, mem_ras, mem_cas, mem_cs, mem_rd, mem_addr, req_ready, xfer_done,
                 e_ras, e_cas, e_cs, e_rd, e_addr, e_rdy, e_done);
      end
    end
  end

  task automatic expect_pos(string tag, string what, int v);
    checks++;
    if (v <= 0) begin
      fails++;
      $display("FAIL %s %s act %0d exp >0", tag, what, v);
    end
  endtask

  task automatic send(input logic [ADDR_W-1:0] a, input logic r);
    bit got;
    req_valid = 1; req_addr = a; req_rd = r;
    got = 0;
    while (!got) begin
      @(negedge clk); got = req_ready;
      @(posedge clk); #1;
    end
    req_valid = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    int row;
    void'($urandom(7));
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if ({mem_ras, mem_cas, mem_cs, xfer_done} != 4'b0000 || mem_rd != 1'b1 || req_ready != 1'b1) begin
      fails++;
      $display("FAIL R1 act ras%b cas%b cs%b done%b rd%b rdy%b exp 0000 rd1 rdy1",
               mem_ras, mem_cas, mem_cs, xfer_done, mem_rd, req_ready);
    end
    @(posedge clk); #1;
    rst_n = 1; run = 1;
    row = 0;
    for (int tr = 0; tr < 2000; tr++) begin
      int g, pick;
      logic [31:0] rv;
      g = int'($urandom % 3);
      repeat (g) begin @(posedge clk); #1; end
      if (tr % 50 == 49) repeat (45) begin @(posedge clk); #1; end
      pick = int'($urandom % 10);
      if (pick >= 7) row = int'($urandom % ROWS);
      rv = ($urandom % (1 << COL_W)) | (32'(row) << COL_W);
      send(rv[ADDR_W-1:0], rv[ADDR_W] ^ ($urandom % 2 == 1));
    end
    repeat (20) begin @(posedge clk); #1; end
    run = 0;
    expect_pos("R5", "page hits", n_hit);
    expect_pos("R6", "page misses", n_miss);
    expect_pos("R9", "refresh after open page", n_refclose);
    expect_pos("R9", "hit accepted as timer expired", n_coll);
    expect_pos("R8", "refresh row wraps", n_wrap);
    expect_pos("R7", "refreshes", n_ref);
    expect_pos("R10", "held requests", n_held);
    expect_pos("R3", "reads", n_rd);
    expect_pos("R3", "writes", n_wr);
    fin = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog expired act running exp finished");
      summary();
      $finish;
    end
  end
endmodule